// File: doc/BRIEF.md
# Keyed Write-Enable Unlock

This block protects the write-enable flag of a set of timekeeping registers. It watches a simple write bus and recognises two addresses. One is a key register and the other is a configuration register. The block drives one output, `wr_en_o`. Neighbouring blocks accept writes to their timer registers only while this output is high. The timer registers and their write gating are outside the block.

To raise the enable, software must write two key values to the key register, first `KEY_A` (0x55) and then `KEY_B` (0xAA), close together. It must then write the configuration register with bit `EN_BIT` (13) set, inside a short window after the second key. One such write uses up the unlock. A key that is wrong, late or out of order drops the sequence back to idle. Software can clear the enable at any moment with a configuration write whose bit `EN_BIT` is 0, and no key is needed for that.

The key gap, the window length, the addresses, the key values and the bit position are parameters. When both the key gap and the window are one cycle, the block is built without a timing counter.

Top module: `wen_unlock`

## Requirements
- R1: After reset `wr_en_o` is 0 and the sequencer is idle, so a configuration write with bit 13 set that comes before any key leaves `wr_en_o` at 0.
- R2: A bus write (`bus_wr_i`=1) to `CFG_ADDR` with data bit 13 equal to 0 makes `wr_en_o` 0 from the next clock edge on, in any sequencer state.
- R3: A write to `CFG_ADDR` with bit 13 set while no unlock is open leaves `wr_en_o` unchanged.
- R4: A write to `KEY_ADDR` whose low 8 bits are 0x55, then one whose low 8 bits are 0xAA, opens the unlock. A write to `CFG_ADDR` with bit 13 set in the next `WINDOW` cycles (default 1) then sets `wr_en_o` to 1 at that write's clock edge.
- R5: The 0xAA key must arrive within `KEY_GAP` cycles (default 1, meaning the very next cycle) after the 0x55 key. A later 0xAA key does not open the unlock.
- R6: While the sequencer waits for 0xAA, any other key value, including a second 0x55, returns it to idle. A configuration write at that point also returns it to idle.
- R7: If no configuration write arrives within `WINDOW` cycles after the 0xAA key, the unlock expires and a later set is ignored.
- R8: Key writes never change `wr_en_o`, whether it is 0 or 1.
- R9: The first configuration write after the unlock opens uses it up, whether it sets or clears bit 13. A further set then needs a new key sequence.
- R10: Writes to addresses other than `KEY_ADDR` and `CFG_ADDR` do not change `wr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Write address |
| bus_wdata_i | input | DATA_W | Write data |
| wr_en_o | output | 1 | Timer write enable |

## Verification
The assertions assume at most one bus write per cycle and that the key and configuration addresses differ. Under those assumptions a rise of the enable can be traced to an armed set write, and a fall to a clearing write. The stimulus drives one write or none on each falling edge. It draws addresses only from the key address, the configuration address and one unrelated address. It mixes random key values and random data with whole unlock sequences, so the armed window is reached often.

// File: rtl/wen_pkg.sv
package wen_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HALF = 2'd1,
      SEQ_OPEN = 2'd2
   } seq_state_e;

   function automatic int unsigned wen_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wen_bus_decode.sv
module wen_bus_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h2E,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h3C,
   parameter logic [7:0] KEY_A = 8'h55,
   parameter logic [7:0] KEY_B = 8'hAA,
   parameter int unsigned EN_BIT = 13
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              key_hit_o,
   output logic              cfg_hit_o,
   output logic              key_a_o,
   output logic              key_b_o,
   output logic              cfg_bit_o
);
   logic [7:0] key_byte;

   assign key_byte  = wdata_i[7:0];
   assign key_hit_o = wr_i && (addr_i == KEY_ADDR);
   assign cfg_hit_o = wr_i && (addr_i == CFG_ADDR);
   assign key_a_o   = (key_byte == KEY_A);
   assign key_b_o   = (key_byte == KEY_B);
   assign cfg_bit_o = wdata_i[EN_BIT];
endmodule

// File: rtl/wen_key_seq.sv
module wen_key_seq
   import wen_pkg::*;
#(
   parameter int unsigned KEY_GAP = 1,
   parameter int unsigned WINDOW  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_hit_i,
   input  logic cfg_hit_i,
   input  logic key_a_i,
   input  logic key_b_i,
   output logic armed_o
);
   localparam int unsigned LIM = wen_max(KEY_GAP, WINDOW);
   localparam int unsigned CW  = (LIM > 1) ? $clog2(LIM + 1) : 1;

   seq_state_e state_q, state_d;
   logic       tmr_start, tmr_step, expire;

   assign tmr_start = key_hit_i && !cfg_hit_i;
   assign tmr_step  = !key_hit_i && !cfg_hit_i && (state_q != SEQ_IDLE);

   generate
      if (LIM == 1) begin : g_no_timer
         assign expire = 1'b1;
      end else begin : g_timer
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] limit;
         assign limit  = (state_q == SEQ_HALF) ? CW'(KEY_GAP) : CW'(WINDOW);
         assign expire = (cnt_q >= limit);
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= CW'(1);
            else if (tmr_start)      cnt_q <= CW'(1);
            else if (tmr_step && !expire) cnt_q <= cnt_q + CW'(1);
         end
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (cfg_hit_i) begin
         state_d = SEQ_IDLE;
      end else if (key_hit_i) begin
         if (state_q == SEQ_HALF) state_d = key_b_i ? SEQ_OPEN : SEQ_IDLE;
         else                     state_d = key_a_i ? SEQ_HALF : SEQ_IDLE;
      end else if (state_q != SEQ_IDLE && expire) begin
         state_d = SEQ_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign armed_o = (state_q == SEQ_OPEN);

   // R5
   half_needs_first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_HALF && !$past(state_q == SEQ_HALF)) |-> $past(key_hit_i && key_a_i));
   // R6
   open_needs_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_OPEN && !$past(state_q == SEQ_OPEN))
         |-> $past(key_hit_i && key_b_i && state_q == SEQ_HALF));
   // R9
   open_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_OPEN && cfg_hit_i) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/wen_enable_reg.sv
module wen_enable_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_hit_i,
   input  logic cfg_bit_i,
   input  logic armed_i,
   output logic wen_o
);
   logic wen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   wen_q <= 1'b0;
      else if (cfg_hit_i) begin
         if (!cfg_bit_i)            wen_q <= 1'b0;
         else if (armed_i)          wen_q <= 1'b1;
      end
   end

   assign wen_o = wen_q;

   // R4
   en_rise_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen_q) |-> $past(armed_i && cfg_hit_i && cfg_bit_i));
   // R2
   en_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wen_q) |-> $past(cfg_hit_i && !cfg_bit_i));
endmodule

// File: rtl/wen_unlock.sv
module wen_unlock #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h2E,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h3C,
   parameter logic [7:0] KEY_A = 8'h55,
   parameter logic [7:0] KEY_B = 8'hAA,
   parameter int unsigned EN_BIT  = 13,
   parameter int unsigned KEY_GAP = 1,
   parameter int unsigned WINDOW  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic              wr_en_o
);
   generate
      if (DATA_W < 8)          begin : g_bad_w   $error("DATA_W must hold a key byte"); end
      if (EN_BIT >= DATA_W)    begin : g_bad_bit $error("EN_BIT outside data word"); end
      if (KEY_ADDR == CFG_ADDR) begin : g_bad_adr $error("key and config addresses clash"); end
      if (KEY_A == KEY_B)      begin : g_bad_key $error("key values must differ"); end
      if (KEY_GAP < 1 || WINDOW < 1) begin : g_bad_tm $error("timing limits must be at least 1"); end
   endgenerate

   logic key_hit, cfg_hit, key_a, key_b, cfg_bit, armed;

   wen_bus_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .CFG_ADDR(CFG_ADDR),
      .KEY_A(KEY_A), .KEY_B(KEY_B), .EN_BIT(EN_BIT)
   ) u_dec (
      .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
      .key_hit_o(key_hit), .cfg_hit_o(cfg_hit), .key_a_o(key_a),
      .key_b_o(key_b), .cfg_bit_o(cfg_bit)
   );

   wen_key_seq #(.KEY_GAP(KEY_GAP), .WINDOW(WINDOW)) u_seq (
      .clk(clk), .rst_n(rst_n), .key_hit_i(key_hit), .cfg_hit_i(cfg_hit),
      .key_a_i(key_a), .key_b_i(key_b), .armed_o(armed)
   );

   wen_enable_reg u_en (
      .clk(clk), .rst_n(rst_n), .cfg_hit_i(cfg_hit), .cfg_bit_i(cfg_bit),
      .armed_i(armed), .wen_o(wr_en_o)
   );
endmodule

// File: tb/sim_wen_unlock.sv
module sim_wen_unlock;
   localparam logic [7:0] KA  = 8'h2E;
   localparam logic [7:0] CA  = 8'h3C;
   localparam logic [7:0] OA  = 8'h41;
   localparam int GAP = 1;
   localparam int WIN = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        wr_en;

   int checks = 0;
   int errors = 0;
   int ms = 0;
   int mc = 1;
   logic men = 1'b0;

   always #5 clk = ~clk;

   wen_unlock u0 (.clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
                  .bus_wdata_i(wdata), .wr_en_o(wr_en));

   function automatic int lim_of(input int s);
      return (s == 1) ? GAP : WIN;
   endfunction

   task automatic model(input logic v, input logic [7:0] a, input logic [15:0] d);
      if (v && a == CA) begin
         if (!d[13]) men = 1'b0;
         else if (ms == 2) men = 1'b1;
         ms = 0;
      end else if (v && a == KA) begin
         mc = 1;
         if (ms == 1) ms = (d[7:0] == 8'hAA) ? 2 : 0;
         else         ms = (d[7:0] == 8'h55) ? 1 : 0;
      end else if (ms != 0) begin
         if (mc >= lim_of(ms)) ms = 0;
         else mc = mc + 1;
      end
   endtask

   task automatic cyc(input logic v, input logic [7:0] a, input logic [15:0] d, input string tag);
      @(negedge clk);
      wr = v; addr = a; wdata = d;
      @(posedge clk);
      #1;
      model(v, a, d);
      checks++;
      if (wr_en !== men) begin
         errors++;
         $display("FAIL %s: wr_en_o=%0b expected %0b", tag, wr_en, men);
      end
   endtask

   task automatic expect_lit(input logic e, input string tag);
      checks++;
      if (wr_en !== e) begin
         errors++;
         $display("FAIL %s: wr_en_o=%0b expected %0b", tag, wr_en, e);
      end
   endtask

   task automatic unlock(input string tag);
      cyc(1, KA, 16'h0055, tag);
      cyc(1, KA, 16'h00AA, tag);
   endtask

   initial begin
      #(10 * 200000);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      expect_lit(1'b0, "R1 reset");
      cyc(1, CA, 16'h2000, "R1 set before key");
      expect_lit(1'b0, "R1 set before key");
      // R8 and R4
      cyc(1, KA, 16'h0055, "R8 first key");
      expect_lit(1'b0, "R8 first key");
      cyc(1, KA, 16'h00AA, "R8 second key");
      expect_lit(1'b0, "R8 second key");
      cyc(1, CA, 16'h2000, "R4 armed set");
      expect_lit(1'b1, "R4 armed set");
      cyc(1, KA, 16'h0055, "R8 key while enabled");
      cyc(1, KA, 16'h0012, "R8 key while enabled");
      expect_lit(1'b1, "R8 key while enabled");
      // R10
      cyc(1, OA, 16'h0000, "R10 other address");
      expect_lit(1'b1, "R10 other address");
      // R3 set with no unlock keeps 1; R2 clear
      cyc(1, CA, 16'hFFFF, "R3 set while locked");
      expect_lit(1'b1, "R3 set while locked");
      cyc(1, CA, 16'hDFFF, "R2 clear");
      expect_lit(1'b0, "R2 clear");
      // R7 window expiry
      unlock("R7 window");
      cyc(0, 8'h00, 16'h0, "R7 window");
      cyc(1, CA, 16'h2000, "R7 late set");
      expect_lit(1'b0, "R7 late set");
      // R5 key gap
      cyc(1, KA, 16'h0055, "R5 gap");
      cyc(0, 8'h00, 16'h0, "R5 gap");
      cyc(1, KA, 16'h00AA, "R5 gap");
      cyc(1, CA, 16'h2000, "R5 late second key");
      expect_lit(1'b0, "R5 late second key");
      // R6 repeated first key, and config write between keys
      cyc(1, KA, 16'h0055, "R6 double first");
      cyc(1, KA, 16'h0055, "R6 double first");
      cyc(1, KA, 16'h00AA, "R6 double first");
      cyc(1, CA, 16'h2000, "R6 double first");
      expect_lit(1'b0, "R6 double first");
      cyc(1, KA, 16'h0055, "R6 cfg between keys");
      cyc(1, CA, 16'h0000, "R6 cfg between keys");
      cyc(1, KA, 16'h00AA, "R6 cfg between keys");
      cyc(1, CA, 16'h2000, "R6 cfg between keys");
      expect_lit(1'b0, "R6 cfg between keys");
      // R9 consumed by clear, then by set
      unlock("R9 clear uses unlock");
      cyc(1, CA, 16'h0000, "R9 clear uses unlock");
      cyc(1, CA, 16'h2000, "R9 clear uses unlock");
      expect_lit(1'b0, "R9 clear uses unlock");
      // R4 key compares low byte only; extra data bits ignored
      cyc(1, KA, 16'h3355, "R4 low byte key");
      cyc(1, KA, 16'hC3AA, "R4 low byte key");
      cyc(1, CA, 16'hFFFF, "R4 low byte key");
      expect_lit(1'b1, "R4 low byte key");
      cyc(1, CA, 16'h0000, "R9 second set");
      cyc(1, KA, 16'h0055, "R9 second set");
      cyc(1, KA, 16'h00AA, "R9 second set");
      cyc(1, CA, 16'h0000, "R9 second set");
      cyc(1, CA, 16'h2000, "R9 second set");
      expect_lit(1'b0, "R9 second set");
      // random mix against the model
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic [15:0] d;
         r = $urandom % 8;
         d = 16'($urandom);
         case (r)
            0: cyc(0, 8'h00, d, "R4 random");
            1: cyc(1, OA, d, "R10 random");
            2: cyc(1, KA, {d[15:8], 8'h55}, "R6 random");
            3: cyc(1, KA, {d[15:8], 8'hAA}, "R5 random");
            4: cyc(1, KA, d, "R6 random");
            5: cyc(1, CA, d | 16'h2000, "R3 random");
            6: cyc(1, CA, d & 16'hDFFF, "R2 random");
            default: begin
               unlock("R4 random");
               cyc(1, CA, d, "R4 random");
            end
         endcase
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule